// File: doc/BRIEF.md
# Manchester Word Transmitter with Selectable Sync

This block turns a serially delivered 16-bit word into a Manchester-coded line word on a pair of active-low bipolar drive outputs. A word on the line is a sync character three bit times long, then sixteen Manchester data cells, then one odd-parity cell. The block steps through a word one half-cell at a time on `send_tick`, a one-cycle strobe in the system clock domain that arrives at twice the line bit rate. The block halves this strobe into `shift_clk`, which runs at the bit rate.

A word is requested by raising `enc_enable`. A request made while a word is on the line waits until that word finishes. `sync_cmd_sel` picks one of the two sync shapes, called command and data. The block does not hold the data. It raises `send_data` to ask an external serial source for bits. The source presents each bit before the rising edge of `shift_clk`, and the block samples it on that edge. Pulling `out_inhibit_n` low silences the line drive at once, but the word keeps going in the background.

Top module: `manch_tx`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `bip_pos_n` and `bip_neg_n` are high and `send_data` and `shift_clk` are low.
- R2: `shift_clk` inverts on the clock edge that samples a `send_tick` pulse, and keeps its value on every other edge.
- R3: A word starts on an edge where `send_tick` is high, `shift_clk` is low and `enc_enable` is high, provided no word is active or the active word is in its final half-cell. A request at any other time has no effect, so the start is always aligned to a rising edge of `shift_clk`.
- R4: Each word is 40 half-cells, numbered 0 to 39. `sync_cmd_sel` is sampled only at the start of a word. When it was high, half-cells 0-2 drive positive and half-cells 3-5 drive negative. When it was low, the order is reversed. A later change of `sync_cmd_sel` does not affect the word.
- R5: Data bit k, counted 0 to 15 in arrival order, is the `ser_in` value sampled at the start of half-cell 6+2k, which is a rising edge of `shift_clk`. A one drives positive in half-cell 6+2k and negative in half-cell 7+2k. A zero is the reverse.
- R6: Half-cells 38 and 39 carry a parity bit that makes the total number of ones among the sixteen data bits and the parity bit odd. It uses the same coding as a data bit.
- R7: `send_data` is high exactly during half-cells 5 through 36 of a word. It rises while `shift_clk` is low.
- R8: While `out_inhibit_n` is low, both `bip_pos_n` and `bip_neg_n` are high in the same cycle. The word sequence and the handshake continue unchanged.
- R9: Driving positive means `bip_pos_n` low and `bip_neg_n` high. Driving negative is the reverse. When no word is active, both outputs are high, and the two are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, also clears the divide-by-two |
| send_tick | input | 1 | One-cycle strobe at twice the line bit rate |
| enc_enable | input | 1 | Request to send a word |
| sync_cmd_sel | input | 1 | 1 selects command sync, 0 selects data sync |
| ser_in | input | 1 | Serial data from the external source |
| out_inhibit_n | input | 1 | Low forces both drive outputs inactive |
| shift_clk | output | 1 | Bit-rate shift clock for the source; data sampled on its rise |
| send_data | output | 1 | High while the source must supply data bits |
| bip_pos_n | output | 1 | Active-low positive-sense line drive |
| bip_neg_n | output | 1 | Active-low negative-sense line drive |

## Verification
The assertions assume that `send_tick` is a single-cycle pulse with gaps of at least one cycle, and that it stays low while reset is held. The bench generates the strobe once every four clocks and keeps it off during every reset. The assertions also assume that `ser_in` changes only after a falling edge of `shift_clk`. The bench's source model advances its bit only on that edge, or when `send_data` rises. All inputs change half a clock away from the active edge.

// File: rtl/manch_pkg.sv
// Shared types for the Manchester word transmitter.
// Assumes half-cell numbering from 0 at the start of a word, sync first.
package manch_pkg;

    // Role of a half-cell inside a word.
    typedef enum logic [1:0] {
        FLD_SYNC_LEAD   = 2'd0,
        FLD_SYNC_TRAIL  = 2'd1,
        FLD_CELL_FIRST  = 2'd2,
        FLD_CELL_SECOND = 2'd3
    } field_t;

    // Classify half-cell h given the sync length in bit times.
    function automatic field_t field_of(input int unsigned h, input int unsigned sync_bits);
        if (h < sync_bits)
            return FLD_SYNC_LEAD;
        else if (h < 2 * sync_bits)
            return FLD_SYNC_TRAIL;
        else if ((h % 2) == 0)
            return FLD_CELL_FIRST;
        else
            return FLD_CELL_SECOND;
    endfunction

endpackage

// File: rtl/manch_tx_seq.sv
// Word sequencer: halves the send strobe into the shift clock, accepts
// word requests only on bit boundaries after the previous word, counts
// half-cells and produces the send-data window.
// Assumes send_tick is a single-cycle pulse.
module manch_tx_seq #(
    parameter int unsigned SYNC_BITS = 3,
    parameter int unsigned DATA_BITS = 16,
    parameter int unsigned HC_W      = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            send_tick,
    input  logic            enc_enable,
    input  logic            sync_cmd_sel,
    output logic            phase,
    output logic            busy,
    output logic            cmd_sync,
    output logic            send_data,
    output logic [HC_W-1:0] hc,
    output logic [HC_W-1:0] hc_nxt,
    output logic            cell_go
);
    localparam int unsigned SYNC_HALVES = 2 * SYNC_BITS;
    localparam int unsigned PAR_FIRST   = SYNC_HALVES + 2 * DATA_BITS;
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(PAR_FIRST + 1);
    localparam logic [HC_W-1:0] SEND_LO = HC_W'(SYNC_HALVES - 1);
    localparam logic [HC_W-1:0] SEND_HI = HC_W'(PAR_FIRST - 2);

    logic last_cell;
    logic start;
    logic advance;
    logic [HC_W-1:0] hc_inc;

    // Next-state decode for the word counter.
    always_comb begin
        last_cell = busy && (hc == HC_LAST);
        start     = send_tick && !phase && enc_enable && (!busy || last_cell);
        advance   = send_tick && busy && !last_cell;
        hc_inc    = hc + 1'b1;
        hc_nxt    = start ? '0 : hc_inc;
        cell_go   = start || advance;
    end

    // Divide-by-two of the send strobe; high marks a first half-cell.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= 1'b0;
        else if (send_tick)
            phase <= !phase;
    end

    // Word state: active flag, half-cell count, latched sync and send window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            hc        <= '0;
            cmd_sync  <= 1'b0;
            send_data <= 1'b0;
        end else if (start) begin
            busy      <= 1'b1;
            hc        <= '0;
            cmd_sync  <= sync_cmd_sel;
            send_data <= 1'b0;
        end else if (advance) begin
            hc        <= hc_inc;
            send_data <= (hc_inc >= SEND_LO) && (hc_inc <= SEND_HI);
        end else if (send_tick && last_cell) begin
            busy      <= 1'b0;
            send_data <= 1'b0;
        end
    end

endmodule

// File: rtl/manch_tx_capture.sv
// Serial capture: samples the source bit at the start of every data
// first half-cell, keeps it for the second half and accumulates odd
// parity, which is loaded as the last cell's bit.
// Assumes hc_nxt/cell_go come from the sequencer in the same cycle.
module manch_tx_capture #(
    parameter int unsigned SYNC_BITS = 3,
    parameter int unsigned DATA_BITS = 16,
    parameter int unsigned HC_W      = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cell_go,
    input  logic [HC_W-1:0] hc_nxt,
    input  logic            ser_in,
    output logic            cur_bit
);
    localparam int unsigned SYNC_HALVES = 2 * SYNC_BITS;
    localparam logic [HC_W-1:0] DATA_FIRST = HC_W'(SYNC_HALVES);
    localparam logic [HC_W-1:0] PAR_FIRST  = HC_W'(SYNC_HALVES + 2 * DATA_BITS);

    logic par_acc;
    logic take_bit;
    logic take_par;
    logic word_begin;

    // Decode which half-cell is being entered.
    always_comb begin
        word_begin = cell_go && (hc_nxt == '0);
        take_bit   = cell_go && (hc_nxt >= DATA_FIRST) && (hc_nxt < PAR_FIRST) && !hc_nxt[0];
        take_par   = cell_go && (hc_nxt == PAR_FIRST);
    end

    // Hold the bit being coded and the running odd parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_bit <= 1'b0;
            par_acc <= 1'b1;
        end else if (word_begin) begin
            par_acc <= 1'b1;
        end else if (take_bit) begin
            cur_bit <= ser_in;
            par_acc <= par_acc ^ ser_in;
        end else if (take_par) begin
            cur_bit <= par_acc;
        end
    end

endmodule

// File: rtl/manch_tx_drive.sv
// Line drive: picks the line polarity for the current half-cell and
// turns it into the two active-low drive outputs, gated by the inhibit.
// Assumes the data cells start on an even half-cell.
module manch_tx_drive #(
    parameter int unsigned SYNC_BITS = 3,
    parameter int unsigned HC_W      = 6
) (
    input  logic            busy,
    input  logic            cmd_sync,
    input  logic            cur_bit,
    input  logic [HC_W-1:0] hc,
    input  logic            out_inhibit_n,
    output logic            bip_pos_n,
    output logic            bip_neg_n
);
    import manch_pkg::*;

    field_t fld;
    logic   lvl_pos;
    logic   drive_on;

    // Polarity of the current half-cell.
    always_comb begin
        fld = field_of(int'(hc), SYNC_BITS);
        unique case (fld)
            FLD_SYNC_LEAD:   lvl_pos = cmd_sync;
            FLD_SYNC_TRAIL:  lvl_pos = !cmd_sync;
            FLD_CELL_FIRST:  lvl_pos = cur_bit;
            default:         lvl_pos = !cur_bit;
        endcase
    end

    // Active-low drive pair, quiet when idle or inhibited.
    always_comb begin
        drive_on  = busy && out_inhibit_n;
        bip_pos_n = !(drive_on && lvl_pos);
        bip_neg_n = !(drive_on && !lvl_pos);
    end

endmodule

// File: rtl/manch_tx.sv
// Manchester word transmitter top: sequencer, serial capture and line
// drive. Assumes send_tick is a single-cycle strobe at twice bit rate.
module manch_tx #(
    parameter int unsigned SYNC_BITS = 3,
    parameter int unsigned DATA_BITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic send_tick,
    input  logic enc_enable,
    input  logic sync_cmd_sel,
    input  logic ser_in,
    input  logic out_inhibit_n,
    output logic shift_clk,
    output logic send_data,
    output logic bip_pos_n,
    output logic bip_neg_n
);
    localparam int unsigned HALVES = 2 * SYNC_BITS + 2 * DATA_BITS + 2;
    localparam int unsigned HC_W   = $clog2(HALVES);

    logic            busy;
    logic            cmd_sync;
    logic            cell_go;
    logic            cur_bit;
    logic [HC_W-1:0] hc;
    logic [HC_W-1:0] hc_nxt;

    manch_tx_seq #(.SYNC_BITS(SYNC_BITS), .DATA_BITS(DATA_BITS), .HC_W(HC_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .send_tick    (send_tick),
        .enc_enable   (enc_enable),
        .sync_cmd_sel (sync_cmd_sel),
        .phase        (shift_clk),
        .busy         (busy),
        .cmd_sync     (cmd_sync),
        .send_data    (send_data),
        .hc           (hc),
        .hc_nxt       (hc_nxt),
        .cell_go      (cell_go)
    );

    manch_tx_capture #(.SYNC_BITS(SYNC_BITS), .DATA_BITS(DATA_BITS), .HC_W(HC_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cell_go (cell_go),
        .hc_nxt  (hc_nxt),
        .ser_in  (ser_in),
        .cur_bit (cur_bit)
    );

    manch_tx_drive #(.SYNC_BITS(SYNC_BITS), .HC_W(HC_W)) u_drv (
        .busy          (busy),
        .cmd_sync      (cmd_sync),
        .cur_bit       (cur_bit),
        .hc            (hc),
        .out_inhibit_n (out_inhibit_n),
        .bip_pos_n     (bip_pos_n),
        .bip_neg_n     (bip_neg_n)
    );

endmodule

// File: rtl/manch_tx_chk.sv
// Property checker for the Manchester word transmitter, bound to the top.
// Assumes send_tick is a single-cycle pulse held low during reset.
module manch_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic send_tick,
    input logic out_inhibit_n,
    input logic busy,
    input logic shift_clk,
    input logic send_data,
    input logic bip_pos_n,
    input logic bip_neg_n
);
    AST_SHIFT_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        send_tick |=> (shift_clk != $past(shift_clk))); // R2

    AST_SHIFT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !send_tick |=> $stable(shift_clk)); // R2

    AST_START_ON_BIT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> shift_clk); // R3

    AST_SEND_RISES_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(send_data) |-> !shift_clk); // R7

    AST_SEND_INSIDE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        send_data |-> busy); // R7

    AST_INHIBIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_inhibit_n |-> (bip_pos_n && bip_neg_n)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bip_pos_n && bip_neg_n)); // R9

    AST_NEVER_BOTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bip_pos_n || bip_neg_n)); // R9

endmodule

bind manch_tx manch_tx_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .send_tick     (send_tick),
    .out_inhibit_n (out_inhibit_n),
    .busy          (busy),
    .shift_clk     (shift_clk),
    .send_data     (send_data),
    .bip_pos_n     (bip_pos_n),
    .bip_neg_n     (bip_neg_n)
);

// File: tb/manch_tx_test.sv
module manch_tx_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic send_tick = 1'b0;
    logic enc_enable = 1'b0;
    logic sync_cmd_sel = 1'b0;
    logic ser_in = 1'b0;
    logic out_inhibit_n = 1'b1;
    logic shift_clk, send_data, bip_pos_n, bip_neg_n;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    bit cmp_on = 0;
    bit tick_on = 0;
    int tick_cnt = 0;

    always #2.5 clk = ~clk; // 200 MHz

    manch_tx uut (
        .clk(clk), .rst_n(rst_n), .send_tick(send_tick), .enc_enable(enc_enable),
        .sync_cmd_sel(sync_cmd_sel), .ser_in(ser_in), .out_inhibit_n(out_inhibit_n),
        .shift_clk(shift_clk), .send_data(send_data), .bip_pos_n(bip_pos_n), .bip_neg_n(bip_neg_n)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Send strobe: one cycle in four.
    always @(negedge clk) begin
        tick_cnt = (tick_cnt + 1) % 4;
        send_tick <= tick_on && (tick_cnt == 3);
    end

    // External serial source, MSB first.
    logic [15:0] src_q[$];
    logic [15:0] cur_src = 16'h0;
    int src_idx = 0;
    bit prev_send = 0, prev_shift = 0;
    always @(negedge clk) begin
        if (send_data && !prev_send) begin
            cur_src = (src_q.size() > 0) ? src_q.pop_front() : 16'h0000;
            src_idx = 0;
        end else if (send_data && prev_shift && !shift_clk) begin
            src_idx++;
        end
        if (src_idx < 16) ser_in <= cur_src[15 - src_idx];
        prev_send = send_data;
        prev_shift = shift_clk;
    end

    // Behavioural reference model, updated on each rising edge.
    int  m_ph = 0, m_busy = 0, m_h = 0, m_cmd = 0, m_cur = 0, m_ones = 0, m_lvl = 0, m_send = 0;
    int  m_rx[$];
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_busy = 0; m_h = 0; m_send = 0; m_rx.delete();
        end else if (send_tick) begin
            int old_ph;
            old_ph = m_ph;
            m_ph = 1 - m_ph;
            if (m_busy == 1 && m_h < 39) begin
                m_h++;
            end else if ((m_busy == 0 || m_h == 39) && old_ph == 0 && enc_enable) begin
                m_busy = 1; m_h = 0; m_cmd = sync_cmd_sel; m_ones = 0; m_rx.delete();
            end else if (m_busy == 1) begin
                m_busy = 0;
            end
            if (m_busy == 1) begin
                if (m_h < 3) m_lvl = m_cmd;
                else if (m_h < 6) m_lvl = 1 - m_cmd;
                else if (m_h < 38) begin
                    if (m_h % 2 == 0) begin
                        m_cur = ser_in; m_ones += m_cur; m_rx.push_back(m_cur); m_lvl = m_cur;
                    end else m_lvl = 1 - m_cur;
                end else if (m_h == 38) begin
                    m_cur = (m_ones % 2 == 0) ? 1 : 0; m_lvl = m_cur;
                    // R5: the handshake delivered the source word in order.
                    begin
                        int got;
                        got = 0;
                        foreach (m_rx[i]) got = got * 2 + m_rx[i];
                        check("R5", "captured word", got, cur_src);
                    end
                end else m_lvl = 1 - m_cur;
            end
            m_send = (m_busy == 1 && m_h >= 5 && m_h <= 36) ? 1 : 0;
        end
    end

    // Compare on every clock, one step after the falling edge.
    always @(negedge clk) begin
        #1;
        if (cmp_on && !done) begin
            int ep, en;
            ep = (out_inhibit_n && m_busy == 1 && m_lvl == 1) ? 0 : 1;
            en = (out_inhibit_n && m_busy == 1 && m_lvl == 0) ? 0 : 1;
            check("R2", "shift_clk", shift_clk, m_ph);
            check("R7", "send_data", send_data, m_send);
            check("R3 R4 R5 R6 R8 R9", "bip_pos_n", bip_pos_n, ep);
            check("R3 R4 R5 R6 R8 R9", "bip_neg_n", bip_neg_n, en);
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic request(input bit cmd, input logic [15:0] w);
        src_q.push_back(w);
        @(negedge clk);
        sync_cmd_sel = cmd;
        enc_enable = 1'b1;
        wait_clk(8);
        enc_enable = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        // R1: reset state
        wait_clk(3);
        #1;
        check("R1", "reset bip_pos_n", bip_pos_n, 1);
        check("R1", "reset bip_neg_n", bip_neg_n, 1);
        check("R1", "reset send_data", send_data, 0);
        check("R1", "reset shift_clk", shift_clk, 0);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1;
        wait_clk(4);
        tick_on = 1;

        request(1'b1, 16'hA5C3);          // command sync, mixed data
        wait_clk(180);
        request(1'b0, 16'h0000);          // data sync, parity one
        wait_clk(180);

        // R3 R4: back-to-back words, sync changed mid-word is ignored
        src_q.push_back(16'hFFFF);
        src_q.push_back(16'h1234);
        src_q.push_back(16'h8001);
        sync_cmd_sel = 1'b1;
        enc_enable = 1'b1;
        wait_clk(90);
        sync_cmd_sel = 1'b0;
        wait_clk(200);
        enc_enable = 1'b0;
        wait_clk(200);

        // R3: request during an active word has no effect
        request(1'b0, 16'h7E18);
        wait_clk(40);
        enc_enable = 1'b1;
        wait_clk(4);
        enc_enable = 1'b0;
        wait_clk(160);

        // R8: inhibit in the middle of a word
        request(1'b1, 16'hC0DE);
        wait_clk(60);
        out_inhibit_n = 1'b0;
        wait_clk(24);
        out_inhibit_n = 1'b1;
        wait_clk(120);

        // R1: reset in the middle of a word, then a clean word
        request(1'b1, 16'h5555);
        wait_clk(70);
        tick_on = 0;
        wait_clk(4);
        rst_n = 1'b0;
        wait_clk(2);
        #1;
        check("R1", "mid-word reset bip_pos_n", bip_pos_n, 1);
        check("R1", "mid-word reset send_data", send_data, 0);
        @(negedge clk);
        rst_n = 1'b1;
        src_q.delete();
        wait_clk(4);
        tick_on = 1;
        request(1'b0, 16'h0F0F);
        wait_clk(200);
        finish_run();
    end

    // Watchdog
    initial begin
        #100000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule